// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block keeps the transmit state of one aggregation queue. That queue may have up to 64 frames in flight under a block acknowledgment agreement. The scheduler reports each frame it hands to the radio. The block then records, for every slot in the sliding window, whether the frame has gone out and whether the receiver has confirmed it. The window start is the queue read pointer. Frames are named by 8-bit ring indices, which are sequence numbers modulo 256.

A block-ack report carries a starting sequence number and a 64-bit bitmap. Bit i of the bitmap confirms sequence number (start + i) mod 256. Only bits that land on frames currently in the window take effect. After a report is applied, the window start moves past every acknowledged frame at its head in a single step, so completions may arrive out of order. Frames that were sent, are covered by the report and are still unconfirmed are queued for retransmission. The block lists them one per cycle in ascending order. The space-left output tells the scheduler whether it may issue another new frame, given the configured window size and the per-aggregate frame limit.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset, the window start is 0, no retransmit request is presented, and space-left is 1 when both configuration fields are nonzero.
- R2: A send event opens a new frame only if its index equals window start plus the outstanding count and space-left is 1. Any other send index outside the window is ignored.
- R3: Space-left is 1 exactly when the outstanding count is below both the configured window size and 64. A window size of 0 therefore blocks all new frames.
- R4: The frame limit caps how many new frames may be opened between two block-ack reports. The count restarts at 0 with every report, and a limit of 0 blocks new frames.
- R5: Bitmap bit i refers to index (start + i) mod 256. Bits that refer to indices outside the current window are ignored.
- R6: In the cycle after a report, the window start has advanced past every consecutive acknowledged frame at the head. Without a report, the window start holds.
- R7: Unacknowledged sent frames covered by a report appear on the retransmit output one per cycle, starting the cycle after the report, in ascending order of offset from the window start. Nothing appears without a report.
- R8: A frame listed for retransmission is not listed again by later reports until a send event with its index marks it sent once more. After that resend, a report can acknowledge it or list it again.
- R9: All index arithmetic wraps modulo 256, both for the window start and for the retransmit indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWinSize | input | 7 | Window size in frames (values above 64 act as 64) |
| cfgFrameLimit | input | 7 | Maximum new frames per report interval |
| sendValid | input | 1 | A frame was handed to the radio |
| sendIdx | input | 8 | Ring index of the sent frame |
| baValid | input | 1 | A block-ack report is present |
| baSsn | input | 8 | Starting index of the report bitmap |
| baBitmap | input | 64 | Acknowledgment bits, bit i for index baSsn+i |
| winStart | output | 8 | First index of the window (queue read pointer) |
| spaceLeft | output | 1 | Another new frame may be issued |
| retxValid | output | 1 | A retransmit request is presented this cycle |
| retxIdx | output | 8 | Index of the frame to retransmit |

## Verification
The assertions check the following on every cycle:
- every retransmit index lies inside the window;
- successive requests climb in offset while no report arrives;
- the window start never moves without a report and never jumps more than 64;
- a zero window size or frame limit holds space-left low.

Only the bench scenarios can show the rest: the exact slide distance and the exact retransmit list for a given bitmap, the frame-limit restart, the wrap at index 256, and the rule that a listed frame stays quiet until it is resent. For that, the bench sweeps all 256 bitmaps over an eight-frame window and computes the expected head and list arithmetically.

// File: rtl/bawt_pkg.sv
package bawt_pkg;

  // Strobes raised by the control for one cycle; the datapath acts on them.
  typedef struct packed {
    logic newStb;    // open the frame at the window tail
    logic retryStb;  // mark a resent frame as sent again
    logic baStb;     // apply the block-ack report
    logic popStb;    // retire the presented retransmit request
  } ctlStrobes_t;

endpackage

// File: rtl/bawt_datapath.sv
module bawt_datapath
  import bawt_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int WIN_LOG2 = 6,
  parameter int CFG_W    = 7,
  localparam int NSLOT   = 1 << WIN_LOG2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         stb,
  input  logic [IDX_W-1:0]    sendIdx,
  input  logic [IDX_W-1:0]    baSsn,
  input  logic [NSLOT-1:0]    baBitmap,
  output logic [IDX_W-1:0]    winStart,
  output logic [WIN_LOG2:0]   outstanding,
  output logic                slotSent,
  output logic                slotAck,
  output logic                slotPend,
  output logic [CFG_W-1:0]    burstCnt,
  output logic                pendAny,
  output logic [IDX_W-1:0]    retxIdx
);

  logic [NSLOT-1:0]    sentQ, ackQ, pendQ;
  logic [NSLOT-1:0]    sentN, ackN, pendN;
  logic [NSLOT-1:0]    ackMid, pendSet, retire;
  logic [NSLOT-1:0]    ackRot, pendRot;
  logic [IDX_W-1:0]    nextIdx;
  logic [WIN_LOG2-1:0] headSlot, nextSlot, sendSlot, popSlot, firstOff;
  logic [WIN_LOG2:0]   adv;
  logic                run;

  assign outstanding = (WIN_LOG2+1)'(nextIdx - winStart);
  assign headSlot    = winStart[WIN_LOG2-1:0];
  assign nextSlot    = nextIdx[WIN_LOG2-1:0];
  assign sendSlot    = sendIdx[WIN_LOG2-1:0];
  assign slotSent    = sentQ[sendSlot];
  assign slotAck     = ackQ[sendSlot];
  assign slotPend    = pendQ[sendSlot];

  // Per physical slot: offset from head, report coverage, next state.
  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    logic [WIN_LOG2-1:0] off;
    logic [IDX_W-1:0]    rel;
    logic                inWin, covered, bitv;

    assign off     = WIN_LOG2'(g) - headSlot;
    assign inWin   = {1'b0, off} < outstanding;
    assign rel     = winStart + IDX_W'(off) - baSsn;
    assign covered = stb.baStb && inWin && (rel[IDX_W-1:WIN_LOG2] == '0);
    assign bitv    = baBitmap[rel[WIN_LOG2-1:0]];

    assign ackMid[g]  = ackQ[g] | (covered & bitv);
    assign pendSet[g] = covered & ~bitv & sentQ[g] & ~ackQ[g];
    assign retire[g]  = {1'b0, off} < adv;

    assign sentN[g] = ~retire[g] &
                      ((sentQ[g] & ~pendSet[g]) |
                       (stb.newStb   && (nextSlot == WIN_LOG2'(g))) |
                       (stb.retryStb && (sendSlot == WIN_LOG2'(g))));
    assign ackN[g]  = ~retire[g] & ackMid[g];
    assign pendN[g] = ~retire[g] &
                      ((pendQ[g] & ~ackMid[g] &
                        ~(stb.popStb && (popSlot == WIN_LOG2'(g)))) |
                       pendSet[g]);
  end

  // Views rotated so that position k is offset k from the window head.
  for (genvar k = 0; k < NSLOT; k++) begin : gRot
    logic [WIN_LOG2-1:0] rotSlot;
    assign rotSlot    = headSlot + WIN_LOG2'(k);
    assign ackRot[k]  = ackMid[rotSlot] & ((WIN_LOG2+1)'(k) < outstanding);
    assign pendRot[k] = pendQ[rotSlot];
  end

  // Run length of acknowledged frames at the head.
  always_comb begin
    adv = '0;
    run = 1'b1;
    for (int k = 0; k < NSLOT; k++) begin
      if (run && ackRot[k]) adv = adv + 1'b1;
      else                  run = 1'b0;
    end
  end

  // Lowest pending offset is presented first.
  always_comb begin
    pendAny  = 1'b0;
    firstOff = '0;
    for (int k = NSLOT - 1; k >= 0; k--) begin
      if (pendRot[k]) begin
        pendAny  = 1'b1;
        firstOff = WIN_LOG2'(k);
      end
    end
  end

  assign popSlot = headSlot + firstOff;
  assign retxIdx = winStart + IDX_W'(firstOff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentQ    <= '0;
      ackQ     <= '0;
      pendQ    <= '0;
      winStart <= '0;
      nextIdx  <= '0;
      burstCnt <= '0;
    end else begin
      sentQ    <= sentN;
      ackQ     <= ackN;
      pendQ    <= pendN;
      winStart <= winStart + IDX_W'(adv);
      nextIdx  <= nextIdx + IDX_W'(stb.newStb);
      burstCnt <= stb.baStb ? CFG_W'(stb.newStb) : burstCnt + CFG_W'(stb.newStb);
    end
  end

endmodule

// File: rtl/bawt_control.sv
module bawt_control
  import bawt_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int WIN_LOG2 = 6,
  parameter int CFG_W    = 7,
  localparam int NSLOT   = 1 << WIN_LOG2
) (
  input  logic              sendValid,
  input  logic [IDX_W-1:0]  sendIdx,
  input  logic              baValid,
  input  logic [CFG_W-1:0]  cfgWinSize,
  input  logic [CFG_W-1:0]  cfgFrameLimit,
  input  logic [IDX_W-1:0]  winStart,
  input  logic [WIN_LOG2:0] outstanding,
  input  logic              slotSent,
  input  logic              slotAck,
  input  logic              slotPend,
  input  logic [CFG_W-1:0]  burstCnt,
  input  logic              pendAny,
  output ctlStrobes_t       stb,
  output logic              spaceLeft
);

  logic [IDX_W-1:0] tailIdx, sendOff;
  logic             winRoom, burstRoom;

  assign tailIdx   = winStart + IDX_W'(outstanding);
  assign sendOff   = sendIdx - winStart;
  assign winRoom   = (32'(outstanding) < 32'(cfgWinSize)) &&
                     (32'(outstanding) < NSLOT);
  assign burstRoom = burstCnt < cfgFrameLimit;
  assign spaceLeft = winRoom && burstRoom;

  always_comb begin
    stb.newStb   = sendValid && (sendIdx == tailIdx) && spaceLeft;
    stb.retryStb = sendValid && (32'(sendOff) < 32'(outstanding)) &&
                   !slotSent && !slotAck && !slotPend;
    stb.baStb    = baValid;
    stb.popStb   = pendAny;
  end

endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
  import bawt_pkg::*;
#(
  parameter int IDX_W    = 8,
  parameter int WIN_LOG2 = 6,
  parameter int CFG_W    = 7,
  localparam int NSLOT   = 1 << WIN_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWinSize,
  input  logic [CFG_W-1:0] cfgFrameLimit,
  input  logic             sendValid,
  input  logic [IDX_W-1:0] sendIdx,
  input  logic             baValid,
  input  logic [IDX_W-1:0] baSsn,
  input  logic [NSLOT-1:0] baBitmap,
  output logic [IDX_W-1:0] winStart,
  output logic             spaceLeft,
  output logic             retxValid,
  output logic [IDX_W-1:0] retxIdx
);

  ctlStrobes_t       stb;
  logic [WIN_LOG2:0] outstanding;
  logic              slotSent, slotAck, slotPend, pendAny;
  logic [CFG_W-1:0]  burstCnt;

  bawt_control #(.IDX_W(IDX_W), .WIN_LOG2(WIN_LOG2), .CFG_W(CFG_W)) ctl_i (
    .sendValid(sendValid), .sendIdx(sendIdx), .baValid(baValid),
    .cfgWinSize(cfgWinSize), .cfgFrameLimit(cfgFrameLimit),
    .winStart(winStart), .outstanding(outstanding),
    .slotSent(slotSent), .slotAck(slotAck), .slotPend(slotPend),
    .burstCnt(burstCnt), .pendAny(pendAny),
    .stb(stb), .spaceLeft(spaceLeft)
  );

  bawt_datapath #(.IDX_W(IDX_W), .WIN_LOG2(WIN_LOG2), .CFG_W(CFG_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sendIdx(sendIdx), .baSsn(baSsn), .baBitmap(baBitmap),
    .winStart(winStart), .outstanding(outstanding),
    .slotSent(slotSent), .slotAck(slotAck), .slotPend(slotPend),
    .burstCnt(burstCnt), .pendAny(pendAny), .retxIdx(retxIdx)
  );

  assign retxValid = pendAny;

endmodule

// File: rtl/bawt_checker.sv
module bawt_checker #(
  parameter int IDX_W    = 8,
  parameter int WIN_LOG2 = 6,
  parameter int CFG_W    = 7,
  localparam int NSLOT   = 1 << WIN_LOG2
) (
  input logic             clk,
  input logic             rstN,
  input logic [CFG_W-1:0] cfgWinSize,
  input logic [CFG_W-1:0] cfgFrameLimit,
  input logic             baValid,
  input logic [IDX_W-1:0] winStart,
  input logic             spaceLeft,
  input logic             retxValid,
  input logic [IDX_W-1:0] retxIdx
);

  AST_RETX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    retxValid |-> (IDX_W'(retxIdx - winStart) < IDX_W'(NSLOT))); // R7

  AST_RETX_ASCENDING: assert property (@(posedge clk) disable iff (!rstN)
    (retxValid && !baValid) |=>
      (!retxValid || (IDX_W'(retxIdx - winStart) > IDX_W'($past(retxIdx) - winStart)))); // R7

  AST_RETX_NEEDS_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    (!baValid && !retxValid) |=> !retxValid); // R7

  AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !baValid |=> $stable(winStart)); // R6

  AST_SLIDE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    baValid |=> (IDX_W'(winStart - $past(winStart)) <= IDX_W'(NSLOT))); // R6

  AST_ZERO_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWinSize == '0) |-> !spaceLeft); // R3

  AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFrameLimit == '0) |-> !spaceLeft); // R4

endmodule

bind ba_window_tracker bawt_checker #(.IDX_W(IDX_W), .WIN_LOG2(WIN_LOG2), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rstN(rstN), .cfgWinSize(cfgWinSize), .cfgFrameLimit(cfgFrameLimit),
  .baValid(baValid), .winStart(winStart), .spaceLeft(spaceLeft),
  .retxValid(retxValid), .retxIdx(retxIdx)
);

// File: tb/ba_window_tracker_tb_top.sv
`timescale 1ns/1ps
module ba_window_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  cfgWinSize = 7'd64;
  logic [6:0]  cfgFrameLimit = 7'd127;
  logic        sendValid = 1'b0;
  logic [7:0]  sendIdx = '0;
  logic        baValid = 1'b0;
  logic [7:0]  baSsn = '0;
  logic [63:0] baBitmap = '0;
  logic [7:0]  winStart;
  logic        spaceLeft;
  logic        retxValid;
  logic [7:0]  retxIdx;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ba_window_tracker dut_i (
    .clk(clk), .rstN(rstN), .cfgWinSize(cfgWinSize), .cfgFrameLimit(cfgFrameLimit),
    .sendValid(sendValid), .sendIdx(sendIdx), .baValid(baValid), .baSsn(baSsn),
    .baBitmap(baBitmap), .winStart(winStart), .spaceLeft(spaceLeft),
    .retxValid(retxValid), .retxIdx(retxIdx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(int ws, int fl);
    cfgWinSize = 7'(ws);
    cfgFrameLimit = 7'(fl);
    sendValid = 1'b0;
    baValid = 1'b0;
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  task automatic sendFrame(int idx);
    sendValid = 1'b1;
    sendIdx = 8'(idx);
    tick();
    sendValid = 1'b0;
  endtask

  task automatic blockAck(int ssn, logic [63:0] bmp);
    baValid = 1'b1;
    baSsn = 8'(ssn);
    baBitmap = bmp;
    tick();
    baValid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    doReset(64, 10);
    chk("R1 winStart", winStart, 0);
    chk("R1 retxValid", retxValid, 0);
    chk("R1 spaceLeft", spaceLeft, 1);

    // R3: window size sweep
    for (int ws = 0; ws <= 6; ws++) begin
      doReset(ws, 127);
      for (int k = 0; k <= 7; k++) begin
        chk("R3 spaceLeft vs window", spaceLeft, (k < ws) ? 1 : 0);
        sendFrame(k);
      end
    end
    // R3: window size above 64 acts as 64
    doReset(100, 127);
    for (int k = 0; k < 64; k++) sendFrame(k);
    chk("R3 clamp at 64", spaceLeft, 0);

    // R2: wrong index ignored, tail index accepted
    doReset(1, 127);
    sendFrame(5);
    chk("R2 wrong index ignored", spaceLeft, 1);
    sendFrame(0);
    chk("R3 full at 1", spaceLeft, 0);
    sendFrame(1);
    blockAck(0, 64'h3);
    chk("R2 blocked send not opened", winStart, 1);
    chk("R2 space after slide", spaceLeft, 1);
    chk("R5 bit beyond window no retx", retxValid, 0);

    // R4: frame limit sweep, restarted by a report
    for (int fl = 1; fl <= 4; fl++) begin
      doReset(64, fl);
      for (int k = 0; k <= fl; k++) begin
        chk("R4 spaceLeft vs limit", spaceLeft, (k < fl) ? 1 : 0);
        sendFrame(k);
      end
      blockAck(0, '1);
      chk("R4 only limit frames opened", winStart, fl);
      chk("R4 limit restarts", spaceLeft, 1);
    end
    doReset(64, 0);
    chk("R4 zero limit", spaceLeft, 0);

    // R5/R6/R7: all bitmaps over an eight-frame window
    for (int b = 0; b < 256; b++) begin
      int tz;
      doReset(64, 127);
      for (int k = 0; k < 8; k++) sendFrame(k);
      blockAck(0, 64'(b));
      tz = 0;
      while (tz < 8 && b[tz]) tz++;
      chk("R6 head slide", winStart, tz);
      for (int i = 0; i < 8; i++) begin
        if (!b[i]) begin
          chk("R7 retx valid", retxValid, 1);
          chk("R7 retx index", retxIdx, i);
          tick();
        end
      end
      chk("R7 retx drained", retxValid, 0);
    end

    // R5: report start before the window; outside bits ignored
    doReset(4, 127);
    for (int k = 0; k < 4; k++) sendFrame(k);
    chk("R3 full at 4", spaceLeft, 0);
    blockAck(254, ~64'h3);
    chk("R5 offset start", winStart, 4);
    chk("R5 no retx from outside bits", retxValid, 0);
    sendFrame(4);
    sendFrame(5);
    blockAck(4, 64'h0);
    chk("R5 retx first", retxIdx, 4);
    tick();
    chk("R5 retx second", retxIdx, 5);
    tick();
    chk("R5 drained", retxValid, 0);

    // R8: listed frame stays quiet until resent
    doReset(64, 127);
    sendFrame(0);
    sendFrame(1);
    blockAck(0, 64'h0);
    chk("R8 retx 0", retxIdx, 0);
    tick();
    chk("R8 retx 1", retxIdx, 1);
    tick();
    chk("R8 drained", retxValid, 0);
    blockAck(0, 64'h0);
    chk("R8 not listed again", retxValid, 0);
    sendFrame(0);
    blockAck(0, 64'h0);
    chk("R8 resent listed", retxValid, 1);
    chk("R8 resent index", retxIdx, 0);
    tick();
    chk("R8 only resent", retxValid, 0);
    sendFrame(0);
    sendFrame(1);
    blockAck(0, 64'h3);
    chk("R8 resent acked", winStart, 2);

    // R9: wrap of indices modulo 256
    doReset(64, 127);
    for (int r = 0; r < 5; r++) begin
      int st;
      st = r * 50;
      for (int i = 0; i < 50; i++) sendFrame((st + i) & 255);
      blockAck(st, '1);
    end
    chk("R9 start before wrap", winStart, 250);
    for (int i = 0; i < 10; i++) sendFrame((250 + i) & 255);
    blockAck(250, 64'h37F);
    chk("R9 start after wrap", winStart, 1);
    chk("R9 retx wrapped index", retxIdx, 1);
    tick();
    chk("R9 drained", retxValid, 0);
    sendFrame(1);
    blockAck(1, 64'h1);
    chk("R9 slide over acked tail", winStart, 4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule